// File: doc/BRIEF.md
# Exchangeable Pipeline and Shadow Register Pair

This block holds a parallel pipeline register and a serial shadow register of the same width. The pipeline register feeds an output port. The shadow register can shift serially, which lets it capture or inject a word for diagnostics. It can also load in parallel from the output port or from the pipeline register, or swap contents with the pipeline register in a single cycle. A registered drive flag lets the shadow register present its contents back on the input port.

Both ports are modelled as separate data-in, data-out and enable signals. Two strobes stand in for the two register clocks. `sclk_stb_i` advances the shadow register and the drive flag. `oclk_stb_i` advances the pipeline register. Both strobes are sampled on one system clock. `mode_i`, `sdi_i` and the active-low `y_oe_ni` choose the operation.

Top module: `xfer_pair`

## Requirements
- R1: While `rst_ni` is low, the pipeline register, the shadow register and the drive flag are all zero. So `y_o`, `dq_o` and `dq_oe_o` read 0.
- R2: On `sclk_stb_i` with `mode_i`=0, the shadow register shifts toward its MSB: the new value is {old[W-2:0], sdi_i}. `sdo_o` shows shadow bit W-1 while `mode_i`=0.
- R3: On `sclk_stb_i` with `mode_i`=1, `sdi_i`=0 and `y_oe_ni`=1, the shadow register loads `y_i`.
- R4: On `sclk_stb_i` with `mode_i`=1, `sdi_i`=0 and `y_oe_ni`=0, the shadow register loads the pipeline register's pre-edge value.
- R5: On `oclk_stb_i` with `mode_i`=0, the pipeline register loads `dq_i`.
- R6: On `oclk_stb_i` with `mode_i`=1, the pipeline register loads the shadow register's pre-edge value.
- R7: Both strobes in one cycle with `mode_i`=1, `sdi_i`=0 and `y_oe_ni`=0 swap the two registers.
- R8: While `mode_i`=1, `sdo_o` equals `sdi_i` in the same cycle.
- R9: On `sclk_stb_i` with `mode_i`=1 and `sdi_i`=1, the shadow register holds and `dq_oe_o` becomes 1 from the next cycle. `dq_o` always shows the shadow register.
- R10: On `sclk_stb_i` under any other combination of `mode_i` and `sdi_i`, `dq_oe_o` becomes 0 from the next cycle.
- R11: `y_oe_o` is the inverse of `y_oe_ni`, and `y_o` always shows the pipeline register.
- R12: In a cycle with no strobe, both registers and the drive flag keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Operation select |
| sdi_i | input | 1 | Serial data in; also picks hold or parallel load when mode_i=1 |
| y_oe_ni | input | 1 | Output-port enable, active low; also selects the parallel source |
| sclk_stb_i | input | 1 | Shadow register strobe |
| oclk_stb_i | input | 1 | Pipeline register strobe |
| dq_i | input | WIDTH | Input-port data in |
| dq_o | output | WIDTH | Input-port data out (shadow register) |
| dq_oe_o | output | 1 | Input-port drive enable (registered flag) |
| y_i | input | WIDTH | Output-port data in |
| y_o | output | WIDTH | Output-port data out (pipeline register) |
| y_oe_o | output | 1 | Output-port drive enable |
| sdo_o | output | 1 | Serial data out |

## Verification
The properties assume that every control input and data bus is a known value on each clock edge. They also assume that a strobe is a one-cycle level sampled on that edge, with no separate clock. The bench draws each control bit and both data buses from a seeded `$urandom` on every cycle, so no input is ever left undriven. Directed sequences force the swap, the flag set-then-clear, and a stretch with no strobes. The bench changes inputs only on the falling edge, so the values at each rising edge are settled.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

  typedef enum logic [1:0] {
    SH_SHIFT   = 2'd0,
    SH_LD_PORT = 2'd1,
    SH_LD_PIPE = 2'd2,
    SH_HOLD    = 2'd3
  } sh_op_e;

  function automatic sh_op_e decode_sh_op(input logic mode, input logic sdi,
                                          input logic oe_n);
    if (!mode)    return SH_SHIFT;
    else if (sdi) return SH_HOLD;
    else if (oe_n) return SH_LD_PORT;
    else          return SH_LD_PIPE;
  endfunction

endpackage

// File: rtl/xfer_shadow_reg.sv
module xfer_shadow_reg
  import xfer_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stb_i,
  input  sh_op_e           op_i,
  input  logic             sdi_i,
  input  logic [WIDTH-1:0] port_i,
  input  logic [WIDTH-1:0] pipe_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] q_q, q_d;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic shift_in;
    if (i == 0) begin : g_lsb
      assign shift_in = sdi_i;
    end else begin : g_mid
      assign shift_in = q_q[i-1];
    end
    always_comb begin
      unique case (op_i)
        SH_SHIFT:   q_d[i] = shift_in;
        SH_LD_PORT: q_d[i] = port_i[i];
        SH_LD_PIPE: q_d[i] = pipe_i[i];
        default:    q_d[i] = q_q[i];
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_q <= '0;
    else if (stb_i) q_q <= q_d;
  end

  assign q_o = q_q;

endmodule

// File: rtl/xfer_pipe_reg.sv
module xfer_pipe_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stb_i,
  input  logic             mode_i,
  input  logic [WIDTH-1:0] port_i,
  input  logic [WIDTH-1:0] shadow_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] q_q;

  // shadow_i is the pre-edge value, so a same-cycle shadow load swaps
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_q <= '0;
    else if (stb_i) q_q <= mode_i ? shadow_i : port_i;
  end

  assign q_o = q_q;

endmodule

// File: rtl/xfer_port_ctrl.sv
module xfer_port_ctrl
  import xfer_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   sclk_stb_i,
  input  sh_op_e op_i,
  input  logic   mode_i,
  input  logic   sdi_i,
  input  logic   y_oe_ni,
  input  logic   sh_msb_i,
  output logic   drive_o,
  output logic   sdo_o,
  output logic   y_oe_o
);

  logic drive_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         drive_q <= 1'b0;
    else if (sclk_stb_i) drive_q <= (op_i == SH_HOLD);
  end

  assign drive_o = drive_q;
  assign sdo_o   = mode_i ? sdi_i : sh_msb_i;
  assign y_oe_o  = ~y_oe_ni;

endmodule

// File: rtl/xfer_pair.sv
module xfer_pair
  import xfer_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_i,
  input  logic             sdi_i,
  input  logic             y_oe_ni,
  input  logic             sclk_stb_i,
  input  logic             oclk_stb_i,
  input  logic [WIDTH-1:0] dq_i,
  output logic [WIDTH-1:0] dq_o,
  output logic             dq_oe_o,
  input  logic [WIDTH-1:0] y_i,
  output logic [WIDTH-1:0] y_o,
  output logic             y_oe_o,
  output logic             sdo_o
);

  localparam int MsbIdx = WIDTH - 1;

  sh_op_e           sh_op;
  logic [WIDTH-1:0] shadow_q;
  logic [WIDTH-1:0] pipe_q;

  assign sh_op = decode_sh_op(mode_i, sdi_i, y_oe_ni);

  xfer_shadow_reg #(.WIDTH(WIDTH)) i_shadow (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stb_i  (sclk_stb_i),
    .op_i   (sh_op),
    .sdi_i  (sdi_i),
    .port_i (y_i),
    .pipe_i (pipe_q),
    .q_o    (shadow_q)
  );

  xfer_pipe_reg #(.WIDTH(WIDTH)) i_pipe (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .stb_i    (oclk_stb_i),
    .mode_i   (mode_i),
    .port_i   (dq_i),
    .shadow_i (shadow_q),
    .q_o      (pipe_q)
  );

  xfer_port_ctrl i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sclk_stb_i (sclk_stb_i),
    .op_i       (sh_op),
    .mode_i     (mode_i),
    .sdi_i      (sdi_i),
    .y_oe_ni    (y_oe_ni),
    .sh_msb_i   (shadow_q[MsbIdx]),
    .drive_o    (dq_oe_o),
    .sdo_o      (sdo_o),
    .y_oe_o     (y_oe_o)
  );

  assign dq_o = shadow_q;
  assign y_o  = pipe_q;

endmodule

// File: rtl/xfer_pair_chk.sv
module xfer_pair_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mode_i,
  input logic             sdi_i,
  input logic             y_oe_ni,
  input logic             sclk_stb_i,
  input logic             oclk_stb_i,
  input logic [WIDTH-1:0] dq_i,
  input logic [WIDTH-1:0] dq_o,
  input logic             dq_oe_o,
  input logic [WIDTH-1:0] y_i,
  input logic [WIDTH-1:0] y_o,
  input logic             y_oe_o,
  input logic             sdo_o
);

  p_shift_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_stb_i && !mode_i) |=> dq_o == {$past(dq_o[WIDTH-2:0]), $past(sdi_i)});

  p_sdo_msb_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_i |-> sdo_o == dq_o[WIDTH-1]);

  p_load_port_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_stb_i && mode_i && !sdi_i && y_oe_ni) |=> dq_o == $past(y_i));

  p_load_pipe_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_stb_i && mode_i && !sdi_i && !y_oe_ni) |=> dq_o == $past(y_o));

  p_pipe_dq_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oclk_stb_i && !mode_i) |=> y_o == $past(dq_i));

  p_pipe_sh_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oclk_stb_i && mode_i) |=> y_o == $past(dq_o));

  p_swap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_stb_i && oclk_stb_i && mode_i && !sdi_i && !y_oe_ni)
      |=> (y_o == $past(dq_o)) && (dq_o == $past(y_o)));

  p_sdo_pass_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i |-> sdo_o == sdi_i);

  p_flag_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_stb_i && mode_i && sdi_i) |=> dq_oe_o && $stable(dq_o));

  p_flag_clr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_stb_i && !(mode_i && sdi_i)) |=> !dq_oe_o);

  p_yoe_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    y_oe_o != y_oe_ni);

  p_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sclk_stb_i && !oclk_stb_i)
      |=> $stable(dq_o) && $stable(y_o) && $stable(dq_oe_o));

endmodule

bind xfer_pair xfer_pair_chk #(.WIDTH(WIDTH)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mode_i     (mode_i),
  .sdi_i      (sdi_i),
  .y_oe_ni    (y_oe_ni),
  .sclk_stb_i (sclk_stb_i),
  .oclk_stb_i (oclk_stb_i),
  .dq_i       (dq_i),
  .dq_o       (dq_o),
  .dq_oe_o    (dq_oe_o),
  .y_i        (y_i),
  .y_o        (y_o),
  .y_oe_o     (y_oe_o),
  .sdo_o      (sdo_o)
);

// File: tb/test_xfer_pair.sv
`timescale 1ns/1ps
module test_xfer_pair;

  localparam int W = 8;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         mode_i = 1'b0, sdi_i = 1'b0, y_oe_ni = 1'b1;
  logic         sclk_stb_i = 1'b0, oclk_stb_i = 1'b0;
  logic [W-1:0] dq_i = '0, y_i = '0;
  logic [W-1:0] dq_o, y_o;
  logic         dq_oe_o, y_oe_o, sdo_o;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] m_sh = '0, m_pp = '0;
  logic         m_fl = 1'b0;

  always #4 clk_i = ~clk_i;

  xfer_pair #(.WIDTH(W)) i_xfer_pair (.*);

  task automatic chk(input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] nx_shadow(input logic [W-1:0] sh,
      input logic [W-1:0] pp, input logic m, input logic s, input logic oen,
      input logic [W-1:0] yin);
    if (!m)      return {sh[W-2:0], s};
    else if (s)  return sh;
    else if (oen) return yin;
    else         return pp;
  endfunction

  // one cycle: inputs applied at negedge, comb checked, model advanced at posedge
  task automatic step(input logic m, input logic s, input logic oen,
                      input logic sc, input logic oc, input logic [W-1:0] d,
                      input logic [W-1:0] y);
    logic [W-1:0] n_sh, n_pp;
    mode_i = m; sdi_i = s; y_oe_ni = oen; sclk_stb_i = sc; oclk_stb_i = oc;
    dq_i = d; y_i = y;
    #1;
    chk(m ? "R8" : "R2", {7'd0, sdo_o}, {7'd0, m ? s : m_sh[W-1]});
    chk("R11", {7'd0, y_oe_o}, {7'd0, ~oen});
    n_sh = sc ? nx_shadow(m_sh, m_pp, m, s, oen, y) : m_sh;
    n_pp = oc ? (m ? m_sh : d) : m_pp;
    if (sc) m_fl = m & s;
    m_sh = n_sh; m_pp = n_pp;
    @(negedge clk_i);
    chk("R2-R7 shadow", dq_o, m_sh);
    chk("R5-R7 pipe", y_o, m_pp);
    chk(m_fl ? "R9" : "R10", {7'd0, dq_oe_o}, {7'd0, m_fl});
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk_i);
    chk("R1 pipe", y_o, '0);
    chk("R1 shadow", dq_o, '0);
    chk("R1 flag", {7'd0, dq_oe_o}, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R5 load pipe, R2 shift in a pattern
    step(0, 0, 1, 0, 1, 8'hA5, 8'h00);
    for (int i = 0; i < W; i++) step(0, (8'h3C >> (W-1-i)) & 1'b1, 1, 1, 0, 8'h00, 8'h00);
    chk("R2 pattern", dq_o, 8'h3C);
    // R7 swap
    step(1, 0, 0, 1, 1, 8'h00, 8'hFF);
    chk("R7 swap shadow", dq_o, 8'hA5);
    chk("R7 swap pipe", y_o, 8'h3C);
    // R9 flag set and hold, then R10 clear by R3 load
    step(1, 1, 1, 1, 0, 8'h00, 8'h11);
    chk("R9 drive", {7'd0, dq_oe_o}, 8'd1);
    step(1, 0, 1, 1, 0, 8'h00, 8'h5A);
    chk("R3 load", dq_o, 8'h5A);
    chk("R10 clear", {7'd0, dq_oe_o}, 8'd0);
    // R4 shadow from pipe, R6 pipe from shadow
    step(1, 0, 0, 1, 0, 8'h00, 8'h00);
    chk("R4 load", dq_o, 8'h3C);
    step(1, 1, 0, 0, 1, 8'h00, 8'h00);
    chk("R6 load", y_o, 8'h3C);
    // R12 no strobes
    for (int i = 0; i < 5; i++) step($urandom, $urandom, $urandom, 0, 0, $urandom, $urandom);
    chk("R12 hold", dq_o, 8'h3C);

    for (int i = 0; i < 2000; i++)
      step($urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule